// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

The sequencer runs a 4-wire resistive touch panel by switching it between an X-measure and a Y-measure electrode configuration. A periodic tick (typically every 1 ms) starts one ADC conversion. Each completed conversion moves a five-state sequence forward by one step. Right after each change of axis, the first conversion is thrown away so that the panel can settle, and the second conversion is kept as the reading for that axis.

While one layer is driven end to end, the other layer serves as the sense layer. In the settling step, both ends of the sense layer are first pulled low to drain any charge left on it. For the kept reading, the sense layer is released, and its positive electrode is placed in analog mode and routed to the ADC. Once both readings of a pass have been taken, the block reports the pair. It flags a touch only when both readings reach a configurable minimum level. The ADC, the averaging it does inside each conversion, the calibration and the pads themselves all lie outside this block.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset the sequence is in its initial step. In that step `conv_req` and `pair_valid` are 0, `pad_oe` is 4'b1111, `pad_lvl` is 4'b0000, `pad_analog` is 2'b00 and `chan_sel` is 0.
- R2: A tick that arrives while no conversion is pending makes `conv_req` high for exactly one cycle, in the cycle after the tick.
- R3: A tick that arrives while a conversion is pending (from a request until its `conv_done`, including the `conv_done` cycle itself) is ignored and is not queued.
- R4: Each `conv_done` on a pending conversion advances the sequence by one step, in the order INIT, SKIP_X, READ_X, SKIP_Y, READ_Y. After READ_Y the sequence returns to SKIP_X. INIT is entered only from reset.
- R5: The electrode bits are xp=bit0, xn=bit1, yp=bit2, yn=bit3, and `pad_analog` is bit0=xp, bit1=yp. The outputs per step (oe/lvl/analog) are: INIT 1111/0000/00, SKIP_X 1111/0001/00, READ_X 0011/0001/10, SKIP_Y 1111/0100/00, READ_Y 1100/0100/01. In both SKIP steps the idle layer is therefore driven low at both ends.
- R6: `chan_sel` is 0 (yp sensed) in INIT, SKIP_X and READ_X, and 1 (xp sensed) in SKIP_Y and READ_Y. It changes in the same cycle as the drive pattern and stays stable while a conversion is pending.
- R7: In the cycle after the READ_Y completion, `pair_valid` is high for one cycle. `pos_x` then holds the data of the READ_X completion and `pos_y` holds the data of the READ_Y completion. Data from the INIT and SKIP completions never reaches the outputs.
- R8: `touched` is 1 with a pair only when both `pos_x` and `pos_y` are greater than or equal to `min_level`. Otherwise it is 0 and reports no touch.
- R9: A `conv_done` that arrives while no conversion is pending has no effect on the sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Periodic sampling trigger |
| min_level | input | DATA_W | Minimum reading that counts as a touch |
| conv_done | input | 1 | ADC conversion complete, one cycle |
| conv_data | input | DATA_W | ADC result, valid with conv_done |
| conv_req | output | 1 | Start-conversion pulse to the ADC |
| chan_sel | output | 1 | ADC channel: 0 = yp sense, 1 = xp sense |
| pad_oe | output | 4 | Electrode output enables {yn,yp,xn,xp} |
| pad_lvl | output | 4 | Electrode drive levels {yn,yp,xn,xp} |
| pad_analog | output | 2 | Analog mode {yp,xp} |
| pair_valid | output | 1 | One-cycle strobe for a finished X/Y pair |
| touched | output | 1 | Pair is a touch (both at or above min_level) |
| pos_x | output | DATA_W | Kept X reading |
| pos_y | output | DATA_W | Kept Y reading |

## Verification
The request pulse appears one cycle after the tick. The new drive pattern, the channel select and the pair strobe all appear one cycle after the accepted completion, because each of them comes through a single register stage. The bench changes inputs on falling edges and reads outputs on the falling edge that follows the relevant rising edge. A driver task places the expected pair in a queue just before it raises the READ_Y completion. A monitor removes one entry on each strobe, so a late, early, missing or extra strobe shows up as a mismatch or as a strobe with an empty queue.

// File: rtl/touch_scan_seq.sv
module touch_scan_seq #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] min_level,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              conv_req,
  output logic              chan_sel,
  output logic [3:0]        pad_oe,
  output logic [3:0]        pad_lvl,
  output logic [1:0]        pad_analog,
  output logic              pair_valid,
  output logic              touched,
  output logic [DATA_W-1:0] pos_x,
  output logic [DATA_W-1:0] pos_y
);
  typedef enum logic [2:0] {ST_INIT, ST_SKIP_X, ST_READ_X, ST_SKIP_Y, ST_READ_Y} st_t;

  st_t st, st_nx;
  logic busy;
  logic [DATA_W-1:0] x_hold;
  logic accept;

  assign accept = busy & conv_done;

  always_comb begin
    case (st)
      ST_INIT:   st_nx = ST_SKIP_X;
      ST_SKIP_X: st_nx = ST_READ_X;
      ST_READ_X: st_nx = ST_SKIP_Y;
      ST_SKIP_Y: st_nx = ST_READ_Y;
      default:   st_nx = ST_SKIP_X;
    endcase
  end

  always_comb begin
    case (st)
      ST_SKIP_X: begin pad_oe = 4'b1111; pad_lvl = 4'b0001; pad_analog = 2'b00; chan_sel = 1'b0; end
      ST_READ_X: begin pad_oe = 4'b0011; pad_lvl = 4'b0001; pad_analog = 2'b10; chan_sel = 1'b0; end
      ST_SKIP_Y: begin pad_oe = 4'b1111; pad_lvl = 4'b0100; pad_analog = 2'b00; chan_sel = 1'b1; end
      ST_READ_Y: begin pad_oe = 4'b1100; pad_lvl = 4'b0100; pad_analog = 2'b01; chan_sel = 1'b1; end
      default:   begin pad_oe = 4'b1111; pad_lvl = 4'b0000; pad_analog = 2'b00; chan_sel = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_INIT;
      busy       <= 1'b0;
      conv_req   <= 1'b0;
      pair_valid <= 1'b0;
      touched    <= 1'b0;
      x_hold     <= '0;
      pos_x      <= '0;
      pos_y      <= '0;
    end else begin
      conv_req   <= tick & ~busy;
      pair_valid <= 1'b0;
      if (tick && !busy)
        busy <= 1'b1;
      else if (conv_done)
        busy <= 1'b0;
      if (accept) begin
        st <= st_nx;
        if (st == ST_READ_X)
          x_hold <= conv_data;
        if (st == ST_READ_Y) begin
          pos_x      <= x_hold;
          pos_y      <= conv_data;
          touched    <= (x_hold >= min_level) && (conv_data >= min_level);
          pair_valid <= 1'b1;
        end
      end
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  p_no_req_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_req);

  p_chan_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> ($stable(chan_sel) && $stable(pad_lvl) && $stable(pad_oe)));

  p_pair_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st == ST_READ_Y) |=> pair_valid);

  p_pair_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy) |=> $stable(st));

  p_init_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_INIT) |=> (st != ST_INIT));
endmodule

// File: tb/sim_touch_scan_seq.sv
module sim_touch_scan_seq;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, conv_done = 1'b0;
  logic [W-1:0] min_level = 12'd40, conv_data = '0;
  logic conv_req, chan_sel, pair_valid, touched;
  logic [3:0] pad_oe, pad_lvl;
  logic [1:0] pad_analog;
  logic [W-1:0] pos_x, pos_y;
  int checks = 0, fails = 0, cyc = 0, bst = 0;
  logic [W-1:0] bx = '0;
  logic [2*W:0] expq[$];

  touch_scan_seq #(.DATA_W(W)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] cfg(input int s);
    case (s)
      1: cfg = {4'b1111, 4'b0001, 2'b00, 1'b0};
      2: cfg = {4'b0011, 4'b0001, 2'b10, 1'b0};
      3: cfg = {4'b1111, 4'b0100, 2'b00, 1'b1};
      4: cfg = {4'b1100, 4'b0100, 2'b01, 1'b1};
      default: cfg = {4'b1111, 4'b0000, 2'b00, 1'b0};
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && pair_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R7 actual=strobe expected=no strobe");
      end else begin
        logic [2*W:0] e;
        e = expq.pop_front();
        if ({touched, pos_x, pos_y} !== e) begin
          fails++;
          $display("FAIL R7/R8 actual=%h expected=%h", {touched, pos_x, pos_y}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic do_conv(input logic [W-1:0] d);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R2 req", conv_req, 1'b1);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R2/R3 req low while pending", conv_req, 1'b0);
    chk("R6 stable while pending", {pad_oe, pad_lvl, pad_analog, chan_sel}, cfg(bst));
    if (bst == 4)
      expq.push_back({(bx >= min_level) && (d >= min_level), bx, d});
    if (bst == 2) bx = d;
    conv_done = 1'b1; conv_data = d; tick = 1'b1;
    @(negedge clk) conv_done = 1'b0; tick = 1'b0;
    bst = (bst == 4) ? 1 : bst + 1;
    chk("R4/R5/R6 config", {pad_oe, pad_lvl, pad_analog, chan_sel}, cfg(bst));
    @(negedge clk);
    chk("R3 tick at completion ignored", conv_req, 1'b0);
  endtask

  task automatic do_pair(input logic [W-1:0] x, input logic [W-1:0] y);
    do_conv(12'hAAA);
    do_conv(x);
    do_conv(12'h555);
    do_conv(y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 config", {pad_oe, pad_lvl, pad_analog, chan_sel}, cfg(0));
    chk("R1 req", conv_req, 1'b0);
    chk("R1 pair", pair_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    conv_done = 1'b1; conv_data = 12'h123;
    @(negedge clk) conv_done = 1'b0;
    @(negedge clk);
    chk("R9 stray done", {pad_oe, pad_lvl, pad_analog, chan_sel}, cfg(0));
    do_conv(12'hFFF);
    do_pair(12'd300, 12'd500);
    do_pair(12'd39, 12'd900);
    do_pair(12'd900, 12'd10);
    do_pair(12'd40, 12'd40);
    min_level = 12'd70;
    do_pair(12'd69, 12'd70);
    do_pair(12'd70, 12'd4095);
    conv_done = 1'b1; conv_data = 12'h0;
    @(negedge clk) conv_done = 1'b0;
    @(negedge clk);
    chk("R9 stray done after pair", {pad_oe, pad_lvl, pad_analog, chan_sel}, cfg(bst));
    repeat (4) @(negedge clk);
    chk("R7 all pairs seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule